// File: doc/BRIEF.md
# Line-Start Video Blanking Gate

A serial pixel generator drives its output to the bright level for a short time when it starts each active line. Because this bright run always appears at the same delay after line sync, a window of fixed length can cover it. This block opens such a window on every falling edge of line sync and sends the pixel stream through a gate. While the window is open, the gate forces the output to the background level of the current screen half.

The background level is not always black. The upper and lower halves of the screen can each be shown in inverse video, where the whole area is white. The inverse option pin is only valid during vertical retrace. The block stores one option bit for each half during retrace, using the half-screen flag to pick the half. During active display it uses only the stored bits. The window length is a programmable count of clock cycles, read when each window starts.

Top module: `line_blank_gate`

## Requirements
- R1: After reset, `blank_o` is low, both stored inverse bits are 0 (normal), and `pix_o` equals `pix_raw_i` until the first window opens.
- R2: While no window is open, `pix_o` equals `pix_raw_i` in the same cycle, whatever the inverse settings are.
- R3: The block detects a falling sync edge when `line_sync_i` is sampled high on one rising clock edge and low on the next. On the second rising edge after the low sample, the counter loads `blank_len_i`. `blank_o` is then high for exactly that many cycles.
- R4: If `blank_len_i` is 0 when a falling sync edge is detected, no window opens and `blank_o` stays low.
- R5: A falling sync edge detected while a window is open restarts the count from the `blank_len_i` value present at that load.
- R6: While `blank_o` is high and the selected half is in normal mode (stored bit 0), `pix_o` is 0.
- R7: While `blank_o` is high and the selected half is inverse (stored bit 1), `pix_o` is 1 with the default mask variant. With the pass-through variant, `pix_o` follows `pix_raw_i`.
- R8: On each rising edge with `vretrace_i` high, the block stores the option value sampled two edges earlier. It goes into slot `half_sel_i` (0 = upper half, 1 = lower half). Each slot is written only while its own half is selected.
- R9: Changes on `inv_opt_i` while `vretrace_i` is low have no effect on `pix_o`.
- R10: The current value of `half_sel_i` selects which stored bit sets the mask level. If the flag changes inside a window, the mask level changes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_sync_i | input | 1 | Line sync (active low), asynchronous |
| vretrace_i | input | 1 | High during vertical retrace |
| half_sel_i | input | 1 | Half-screen flag: 0 upper, 1 lower |
| inv_opt_i | input | 1 | Inverse-video option, asynchronous, valid only in retrace |
| pix_raw_i | input | 1 | Raw serial pixel stream |
| blank_len_i | input | LEN_W | Window length in clock cycles |
| pix_o | output | 1 | Gated pixel |
| blank_o | output | 1 | High while the blanking window is open |

## Verification
A wrong count in the window timer shows on `blank_o`. The window opens one cycle early or late, closes at the wrong point, or fails to restart. These errors show within one window length after the sync edge that caused them. A wrong stored inverse bit does not show until the next window of that half, when `pix_o` takes the wrong mask level. That can be up to half a frame after retrace. Because of this, the bench runs lines in both halves with every pair of stored bits, and checks `pix_o` on every cycle.

// File: rtl/lbg_pkg.sv
package lbg_pkg;
   // Level used for an inverse half while the window is open
   typedef enum logic {
      MASK_FORCE_WHITE  = 1'b0,
      MASK_PASS_THROUGH = 1'b1
   } inv_mask_e;

   localparam int unsigned NUM_HALVES = 2;
endpackage

// File: rtl/lbg_sync.sv
module lbg_sync #(
   parameter int unsigned WIDTH  = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[g] <= '0;
            else        stage_q[g] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[g] <= '0;
            else        stage_q[g] <= stage_q[g-1];
         end
      end
   end

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/lbg_timer.sv
module lbg_timer #(
   parameter int unsigned LEN_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sync_s,
   input  logic [LEN_W-1:0] len,
   output logic             fall,
   output logic [LEN_W-1:0] cnt,
   output logic             active
);
   logic sync_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_d <= 1'b0;
      else        sync_d <= sync_s;
   end

   assign fall = sync_d & ~sync_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt <= '0;
      else if (fall)          cnt <= len;
      else if (cnt != '0)     cnt <= cnt - 1'b1;
   end

   assign active = (cnt != '0);
endmodule

// File: rtl/lbg_inv_store.sv
module lbg_inv_store #(
   parameter int unsigned HALVES = lbg_pkg::NUM_HALVES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              opt_s,
   input  logic              vretrace,
   input  logic              half_sel,
   output logic [HALVES-1:0] store
);
   for (genvar h = 0; h < HALVES; h++) begin : g_half
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                   store[h] <= 1'b0;
         else if (vretrace && (32'(half_sel) == h))    store[h] <= opt_s;
      end
   end
endmodule

// File: rtl/line_blank_gate.sv
module line_blank_gate #(
   parameter int unsigned        LEN_W       = 10,
   parameter int unsigned        SYNC_STAGES = 2,
   parameter lbg_pkg::inv_mask_e INV_MASK    = lbg_pkg::MASK_FORCE_WHITE
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             line_sync_i,
   input  logic             vretrace_i,
   input  logic             half_sel_i,
   input  logic             inv_opt_i,
   input  logic             pix_raw_i,
   input  logic [LEN_W-1:0] blank_len_i,
   output logic             pix_o,
   output logic             blank_o
);
   localparam int unsigned SYNC_W = 2;

   if (LEN_W < 1 || LEN_W > 16) begin : g_bad_len
      $error("line_blank_gate: LEN_W out of range");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("line_blank_gate: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_W-1:0]               sync_vec;
   logic                            sync_line;
   logic                            sync_opt;
   logic                            sync_fall;
   logic [LEN_W-1:0]                win_cnt;
   logic [lbg_pkg::NUM_HALVES-1:0]  inv_store;
   logic                            inv_cur;
   logic                            mask_level;

   lbg_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({inv_opt_i, line_sync_i}),
      .q    (sync_vec)
   );
   assign sync_line = sync_vec[0];
   assign sync_opt  = sync_vec[1];

   lbg_timer #(.LEN_W(LEN_W)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .sync_s(sync_line),
      .len   (blank_len_i),
      .fall  (sync_fall),
      .cnt   (win_cnt),
      .active(blank_o)
   );

   lbg_inv_store #(.HALVES(lbg_pkg::NUM_HALVES)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .opt_s   (sync_opt),
      .vretrace(vretrace_i),
      .half_sel(half_sel_i),
      .store   (inv_store)
   );

   assign inv_cur = inv_store[half_sel_i];

   if (INV_MASK == lbg_pkg::MASK_FORCE_WHITE) begin : g_mask_white
      assign mask_level = inv_cur;
   end else begin : g_mask_pass
      assign mask_level = inv_cur & pix_raw_i;
   end

   assign pix_o = blank_o ? mask_level : pix_raw_i;
endmodule

// File: rtl/lbg_checker.sv
module lbg_checker #(
   parameter int unsigned LEN_W = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             fall,
   input logic [LEN_W-1:0] cnt,
   input logic [LEN_W-1:0] len,
   input logic             blank_o,
   input logic             pix_o,
   input logic             vretrace,
   input logic             half_sel,
   input logic [1:0]       store
);
   // R3: a detected edge with a nonzero length opens the window at that length
   assert_window_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (fall && len != '0) |=> (blank_o && cnt == $past(len)));

   // R4: zero length never opens a window
   assert_zero_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (fall && len == '0) |=> !blank_o);

   // R3, R5: without a new edge an open window counts down by one
   assert_countdown_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (blank_o && !fall) |=> (cnt == LEN_W'($past(cnt) - 1'b1)));

   // R6: normal half is masked to black
   assert_black_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (blank_o && !store[half_sel]) |-> !pix_o);

   // R9: outside retrace the stored option bits never move
   assert_store_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !vretrace |=> $stable(store));
endmodule

bind line_blank_gate lbg_checker #(.LEN_W(LEN_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .fall    (sync_fall),
   .cnt     (win_cnt),
   .len     (blank_len_i),
   .blank_o (blank_o),
   .pix_o   (pix_o),
   .vretrace(vretrace_i),
   .half_sel(half_sel_i),
   .store   (inv_store)
);

// File: tb/sim_line_blank_gate.sv
module sim_line_blank_gate;
   localparam int LEN_W = 10;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             line_sync_i = 1'b1;
   logic             vretrace_i = 1'b0;
   logic             half_sel_i = 1'b0;
   logic             inv_opt_i = 1'b0;
   logic             pix_raw_i = 1'b0;
   logic [LEN_W-1:0] blank_len_i = '0;
   logic             pix_o;
   logic             blank_o;

   always #10 clk = ~clk;

   line_blank_gate #(.LEN_W(LEN_W)) u0 (
      .clk(clk), .rst_n(rst_n), .line_sync_i(line_sync_i), .vretrace_i(vretrace_i),
      .half_sel_i(half_sel_i), .inv_opt_i(inv_opt_i), .pix_raw_i(pix_raw_i),
      .blank_len_i(blank_len_i), .pix_o(pix_o), .blank_o(blank_o)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // reference state built from the requirements
   bit s_h1, s_h2, s_h3, o_h1, o_h2;
   int m_cnt;
   bit m_store [2];
   bit hold_inv;

   function automatic bit exp_blank();
      return m_cnt != 0;
   endfunction

   function automatic bit exp_pix(bit half, bit raw);
      if (!exp_blank()) return raw;
      return m_store[half];
   endfunction

   task automatic check(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_edge(bit sync, bit vr, bit half, bit inv, int len);
      bit fall;
      fall = s_h3 & ~s_h2;
      if (fall) m_cnt = len;
      else if (m_cnt != 0) m_cnt--;
      if (vr) m_store[half] = o_h2;
      s_h3 = s_h2; s_h2 = s_h1; s_h1 = sync;
      o_h2 = o_h1; o_h1 = inv;
   endtask

   task automatic cyc(bit sync, bit vr, bit half, bit inv, bit raw, int len, string tag);
      string ptag;
      @(negedge clk);
      line_sync_i = sync; vretrace_i = vr; half_sel_i = half;
      inv_opt_i = inv; pix_raw_i = raw; blank_len_i = LEN_W'(len);
      #5;
      ptag = !exp_blank() ? "R2" : (m_store[half] ? "R7" : "R6");
      check({"blank_o ", tag}, int'(blank_o), int'(exp_blank()));
      check({"pix_o ", ptag, "/", tag}, int'(pix_o), int'(exp_pix(half, raw)));
      @(posedge clk);
      if (rst_n) model_edge(sync, vr, half, inv, len);
   endtask

   // one line: sync low for lo cycles, then high for hi cycles
   task automatic line(int len, int lo, int hi, bit half, bit noise, string tag);
      for (int i = 0; i < lo; i++)
         cyc(1'b0, 1'b0, half, noise ? 1'($urandom) : hold_inv, 1'($urandom), len, tag);
      for (int i = 0; i < hi; i++)
         cyc(1'b1, 1'b0, half, noise ? 1'($urandom) : hold_inv, 1'($urandom), len, tag);
   endtask

   task automatic retrace(bit top, bit bot, string tag);
      for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 1'b0, top, 1'($urandom), 5, tag);
      for (int i = 0; i < 3; i++) cyc(1'b1, 1'b1, 1'b0, top, 1'($urandom), 5, tag);
      for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 1'b1, bot, 1'($urandom), 5, tag);
      for (int i = 0; i < 3; i++) cyc(1'b1, 1'b1, 1'b1, bot, 1'($urandom), 5, tag);
      for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 1'b1, bot, 1'($urandom), 5, tag);
      hold_inv = bot;
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog R3 actual=hung expected=done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2024));
      s_h1 = 0; s_h2 = 0; s_h3 = 0; o_h1 = 0; o_h2 = 0; m_cnt = 0;
      m_store[0] = 0; m_store[1] = 0; hold_inv = 0;

      // R1: reset state and pass-through until the first edge
      for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'($urandom), 5, "R1");
      @(negedge clk); rst_n = 1'b1;
      for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0, 1'($urandom), 1'b0, 1'(i), 7, "R1");

      // R3/R6: normal-mode window, several lengths
      line(8, 4, 20, 1'b0, 1'b0, "R3");
      line(1, 4, 10, 1'b1, 1'b0, "R3");
      // R4: zero length opens nothing
      line(0, 4, 10, 1'b0, 1'b0, "R4");
      // R5: second edge inside an open window restarts the count
      line(20, 2, 4, 1'b0, 1'b0, "R5");
      line(12, 3, 25, 1'b0, 1'b0, "R5");

      // R8: different inverse settings per half
      retrace(1'b1, 1'b0, "R8");
      line(10, 4, 15, 1'b0, 1'b0, "R8");
      line(10, 4, 15, 1'b1, 1'b0, "R8");
      retrace(1'b0, 1'b1, "R8");
      line(10, 4, 15, 1'b0, 1'b0, "R8");
      line(10, 4, 15, 1'b1, 1'b0, "R8");

      // R10: half flag flips inside an open window
      for (int i = 0; i < 4; i++) cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'($urandom), 16, "R10");
      for (int i = 0; i < 20; i++) cyc(1'b1, 1'b0, 1'(i / 3), 1'b1, 1'($urandom), 16, "R10");

      // R9: option pin toggles during active display
      for (int k = 0; k < 6; k++) line(9, 4, 14, 1'(k), 1'b1, "R9");

      // R7: both halves inverse
      retrace(1'b1, 1'b1, "R7");
      line(6, 4, 12, 1'b0, 1'b0, "R7");
      line(6, 4, 12, 1'b1, 1'b0, "R7");

      // random mix
      for (int f = 0; f < 20; f++) begin
         retrace(1'($urandom), 1'($urandom), "R8");
         for (int l = 0; l < 16; l++) begin
            int len;
            len = ($urandom % 8 == 0) ? 0 : int'($urandom % 40);
            line(len, 2 + int'($urandom % 4), 5 + int'($urandom % 50),
                 (l >= 8), 1'($urandom), "R3");
         end
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule